// File: doc/BRIEF.md
# Programmable Converter Sample-Clock Generator

This block derives the timing for one converter channel from a single master clock. A fixed prescaler divides the master clock by four. A programmable down-counter (the filter divider) then produces a pulse train for a switched-capacitor filter. A toggle stage turns that pulse train into a square filter clock. A second programmable down-counter (the rate divider) counts rising edges of that square clock and emits the conversion-rate strobe. A chip instantiates the block once for each direction, and the copies are identical.

The host programs three values through a small write port: the filter divider length, a signed trim, and the rate divider length. It also writes a 2-bit trim mode. An armed trim lengthens or shortens exactly one filter-divider period by the trim amount. This moves the sample phase without changing the nominal rate. Every write is picked up only when the counter concerned next reloads.

With a 20.736 MHz master clock and the defaults, the filter clock is 288 kHz and the strobe rate is 8 kHz.

Top module: `sample_clk_gen`

## Requirements
- R1: While reset is asserted, all three outputs are low. Reset leaves the filter length at 9 and the rate length at 36. The filter pulse then repeats every 36 clocks and the strobe every 2592 clocks.
- R2: The filter pulse is one clock wide. It repeats every 4*N clocks, where N is the programmed filter length (5 bits). A length of 0 acts as 1.
- R3: The filter clock toggles in the cycle after each filter pulse and holds its value at all other times. It therefore stays high for 4*N clocks and low for 4*N clocks.
- R4: The conversion strobe repeats every 8*N*M clocks, where M is the rate length (6 bits) and a length of 0 acts as 1. The strobe coincides with the filter pulse that drives the filter clock high. For N = 9, M = 40, 36, 30, 20 and 15 give 2880, 2592, 2160, 1440 and 1080 clocks.
- R5: The write port decodes these addresses: 0 is the filter length (data bits 4:0), 1 is the trim (data bits 5:0, two's complement), 2 is the rate length (data bits 5:0) and 3 is the trim mode (data bits 1:0). A write never changes the period in progress. The new value first applies from the next reload of the counter concerned.
- R6: Trim mode 01 makes the filter period that starts at the next filter pulse last 4*(N + trim) clocks. A negative trim shortens it.
- R7: Trim mode 10 makes the filter period that starts at the next filter pulse last 4*(N - trim) clocks.
- R8: Trim modes 00 and 11 leave every filter period at 4*N clocks, whatever the trim value.
- R9: When an adjusted length is below 1, the period is 4 clocks.
- R10: An armed trim mode applies to one filter period only. The mode is cleared at the filter pulse that consumes it, and later periods return to 4*N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 filter length, 1 trim, 2 rate length, 3 trim mode |
| wr_data_i | input | 6 | Write data |
| filt_pulse_o | output | 1 | One-clock pulse at each filter-divider terminal count |
| filt_clk_o | output | 1 | Square filter clock, 50% duty cycle |
| conv_strobe_o | output | 1 | One-clock conversion-rate strobe |

## Verification
All three outputs are decoded combinationally from registers. A write presented before a clock edge is stored at that edge. It does not change an output until the next terminal count of the counter concerned, which comes after the rest of the period in progress (4*N or 8*N*M clocks). The bench therefore checks the time from one output event to the next rather than fixed latencies. Each write is issued just after an event, and the expected list starts with the unchanged period still in progress. After that come the one adjusted period for a trim, or the new period, and then the return to nominal. Outputs are sampled on the falling clock edge, so every interval is counted in whole clocks.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  typedef enum logic [1:0] {
    TRIM_OFF  = 2'b00,
    TRIM_ADD  = 2'b01,
    TRIM_SUB  = 2'b10,
    TRIM_HOLD = 2'b11
  } trim_mode_e;

  typedef enum logic [1:0] {
    REG_FLEN = 2'd0,
    REG_TRIM = 2'd1,
    REG_RLEN = 2'd2,
    REG_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sclk_prescale.sv
`timescale 1ns/1ps
module sclk_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_filt_div.sv
`timescale 1ns/1ps
module sclk_filt_div
  import sclk_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 6,
  parameter int LEN_RST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] trim_i,
  input  logic             mode_wr_i,
  input  trim_mode_e       mode_i,
  output logic             tc_o
);
  localparam int SW = CNT_W + 2;
  localparam logic signed [SW-1:0] ONE = SW'(1);

  logic [CNT_W-1:0]        cnt_q;
  trim_mode_e              mode_q;
  logic signed [SW-1:0]    base, delta, sum;
  logic [CNT_W-1:0]        reload;

  assign base  = $signed({{(SW-LEN_W){1'b0}}, len_i});
  assign delta = $signed({{(SW-CNT_W){trim_i[CNT_W-1]}}, trim_i});

  always_comb begin
    unique case (mode_q)
      TRIM_ADD: sum = base + delta;
      TRIM_SUB: sum = base - delta;
      default:  sum = base;
    endcase
    // lengths below one collapse to a single prescaled tick
    if (sum < ONE) reload = '0;
    else           reload = sum[CNT_W-1:0] - 1'b1;
  end

  assign tc_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(LEN_RST - 1);
    else if (tc_o)   cnt_q <= reload;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  // one-shot: consumed at the terminal count, a same-cycle write stays armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= TRIM_OFF;
    else if (mode_wr_i) mode_q <= mode_i;
    else if (tc_o)      mode_q <= TRIM_OFF;
  end
endmodule

// File: rtl/sclk_rate_div.sv
`timescale 1ns/1ps
module sclk_rate_div #(
  parameter int W   = 6,
  parameter int RST = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] len_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload;

  assign reload = (len_i == '0) ? '0 : len_i - 1'b1;
  assign tc_o   = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= W'(RST - 1);
    else if (tc_o) cnt_q <= reload;
    else if (en_i) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sample_clk_gen.sv
`timescale 1ns/1ps
module sample_clk_gen
  import sclk_pkg::*;
#(
  parameter int PRE_DIV  = 4,
  parameter int FLEN_W   = 5,
  parameter int CNT_W    = 6,
  parameter int RLEN_W   = 6,
  parameter int FLEN_RST = 9,
  parameter int RLEN_RST = 36
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [1:0]                           wr_addr_i,
  input  logic [(CNT_W > RLEN_W ? CNT_W : RLEN_W)-1:0] wr_data_i,
  output logic                                 filt_pulse_o,
  output logic                                 filt_clk_o,
  output logic                                 conv_strobe_o
);
  localparam int DW = (CNT_W > RLEN_W) ? CNT_W : RLEN_W;

  logic [FLEN_W-1:0] flen_q;
  logic [CNT_W-1:0]  trim_q;
  logic [RLEN_W-1:0] rlen_q;
  logic              pre_tick, filt_tc, rate_en, filt_q;
  logic              mode_wr;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(wr_addr_i);
  assign mode_wr = wr_en_i && (sel == REG_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flen_q <= FLEN_W'(FLEN_RST);
      trim_q <= '0;
      rlen_q <= RLEN_W'(RLEN_RST);
    end else if (wr_en_i) begin
      unique case (sel)
        REG_FLEN: flen_q <= wr_data_i[FLEN_W-1:0];
        REG_TRIM: trim_q <= wr_data_i[CNT_W-1:0];
        REG_RLEN: rlen_q <= wr_data_i[RLEN_W-1:0];
        default:  ;
      endcase
    end
  end

  sclk_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  sclk_filt_div #(
    .LEN_W   (FLEN_W),
    .CNT_W   (CNT_W),
    .LEN_RST (FLEN_RST)
  ) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (pre_tick),
    .len_i     (flen_q),
    .trim_i    (trim_q),
    .mode_wr_i (mode_wr),
    .mode_i    (trim_mode_e'(wr_data_i[1:0])),
    .tc_o      (filt_tc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      filt_q <= 1'b0;
    else if (filt_tc) filt_q <= ~filt_q;
  end

  // rate divider advances on rising edges of the square filter clock
  assign rate_en = filt_tc && !filt_q;

  sclk_rate_div #(.W(RLEN_W), .RST(RLEN_RST)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rate_en),
    .len_i  (rlen_q),
    .tc_o   (conv_strobe_o)
  );

  assign filt_pulse_o = filt_tc;
  assign filt_clk_o   = filt_q;

  if (DW < 2) begin : g_bad_width
    initial $error("data width too small for trim mode");
  end
endmodule

// File: rtl/sample_clk_gen_chk.sv
`timescale 1ns/1ps
module sample_clk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic filt_pulse_o,
  input logic filt_clk_o,
  input logic conv_strobe_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!filt_pulse_o && !filt_clk_o && !conv_strobe_o); // R1
    end
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_pulse_o |=> !filt_pulse_o); // R2

  AST_CLK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_pulse_o |=> (filt_clk_o != $past(filt_clk_o))); // R3

  AST_CLK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_pulse_o |=> $stable(filt_clk_o)); // R3

  AST_STROBE_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_o |-> filt_pulse_o); // R4

  AST_STROBE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_o |-> !filt_clk_o ##1 filt_clk_o); // R4
endmodule

bind sample_clk_gen sample_clk_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .filt_pulse_o  (filt_pulse_o),
  .filt_clk_o    (filt_clk_o),
  .conv_strobe_o (conv_strobe_o)
);

// File: tb/sample_clk_gen_bench.sv
`timescale 1ns/1ps
module sample_clk_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [5:0] wr_data_i = '0;
  logic       filt_pulse_o, filt_clk_o, conv_strobe_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // expected intervals, tagged with the requirement they prove
  int    qa[$];  string ra[$];
  int    qb[$];  string rb[$];
  int    qh[$];  string rh[$];

  sample_clk_gen u_sample_clk_gen (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .filt_pulse_o, .filt_clk_o, .conv_strobe_o
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // ---------------- monitor ----------------
  int  cnt_a = 0, cnt_b = 0, cnt_h = 0;
  bit  seen_a = 0, seen_b = 0, seen_h = 0;
  bit  prev_clk = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cnt_a = 0; cnt_b = 0; cnt_h = 0;
      seen_a = 0; seen_b = 0; seen_h = 0; prev_clk = 0;
    end else begin
      cnt_a++; cnt_b++;
      if (filt_pulse_o) begin
        if (seen_a && qa.size() > 0) chk(ra.pop_front(), cnt_a, qa.pop_front());
        seen_a = 1; cnt_a = 0;
      end
      if (conv_strobe_o) begin
        if (seen_b && qb.size() > 0) chk(rb.pop_front(), cnt_b, qb.pop_front());
        seen_b = 1; cnt_b = 0;
      end
      if (filt_clk_o) cnt_h++;
      if (!prev_clk && filt_clk_o) begin seen_h = 1; cnt_h = 1; end
      if (prev_clk && !filt_clk_o) begin
        if (seen_h && qh.size() > 0) chk(rh.pop_front(), cnt_h, qh.pop_front());
      end
      prev_clk = filt_clk_o;
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_a();
    @(negedge clk_i iff filt_pulse_o);
    @(posedge clk_i);
  endtask

  task automatic wait_b();
    @(negedge clk_i iff conv_strobe_o);
    @(posedge clk_i);
  endtask

  task automatic push_a(input string r, input int v);
    qa.push_back(v); ra.push_back(r);
  endtask

  task automatic push_b(input string r, input int v);
    qb.push_back(v); rb.push_back(r);
  endtask

  task automatic drain();
    while (qa.size() > 0 || qb.size() > 0 || qh.size() > 0) @(negedge clk_i);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    // R1: outputs quiet under reset
    chk("R1 pulse in reset",  int'(filt_pulse_o), 0);
    chk("R1 clk in reset",    int'(filt_clk_o), 0);
    chk("R1 strobe in reset", int'(conv_strobe_o), 0);
    rst_ni = 1'b1;

    // R1/R2/R3: defaults, length 9
    wait_a();
    push_a("R1 default filter period", 36);
    push_a("R2 filter period", 36);
    qh.push_back(36); rh.push_back("R3 high width");
    qh.push_back(36); rh.push_back("R3 high width");
    drain();

    // R6: add +3, one period of 48, then back (R10)
    wait_a();
    wr(2'd1, 6'd3);
    wr(2'd3, 6'b01);
    push_a("R5 period in progress", 36);
    push_a("R6 add trim", 48);
    push_a("R10 revert after add", 36);
    push_a("R10 stays nominal", 36);
    drain();

    // R7: subtract 3
    wait_a();
    wr(2'd3, 6'b10);
    push_a("R5 period in progress", 36);
    push_a("R7 sub trim", 24);
    push_a("R10 revert after sub", 36);
    drain();

    // R6: negative trim -2 with add
    wait_a();
    wr(2'd1, 6'h3e);
    wr(2'd3, 6'b01);
    push_a("R5 period in progress", 36);
    push_a("R6 add negative trim", 28);
    push_a("R10 revert", 36);
    drain();

    // R8: modes 11 and 00 leave period alone
    wait_a();
    wr(2'd3, 6'b11);
    push_a("R8 mode 11", 36);
    push_a("R8 mode 11", 36);
    push_a("R8 mode 11", 36);
    drain();
    wait_a();
    wr(2'd3, 6'b00);
    push_a("R8 mode 00", 36);
    push_a("R8 mode 00", 36);
    drain();

    // R5: length change applies at next reload
    wait_a();
    wr(2'd0, 6'd5);
    push_a("R5 old length kept", 36);
    push_a("R2 new length 5", 20);
    push_a("R2 new length 5", 20);
    drain();

    // R9: 5 - 7 clamps to one tick
    wait_a();
    wr(2'd1, 6'd7);
    wr(2'd3, 6'b10);
    push_a("R5 period in progress", 20);
    push_a("R9 clamp", 4);
    push_a("R10 revert after clamp", 20);
    drain();

    // R2: length 0 acts as 1
    wait_a();
    wr(2'd0, 6'd0);
    push_a("R5 period in progress", 20);
    push_a("R2 zero length", 4);
    push_a("R2 zero length", 4);
    drain();

    wait_a();
    wr(2'd0, 6'd9);
    push_a("R5 period in progress", 4);
    push_a("R2 restored", 36);
    drain();

    // R4: strobe period for each rate length, old period finishes first (R5)
    begin
      int old = 36;
      int lens[5] = '{40, 36, 30, 20, 15};
      wait_b();
      push_b("R1 default strobe period", 2592);
      drain();
      foreach (lens[i]) begin
        wait_b();
        wr(2'd2, 6'(lens[i]));
        push_b("R5 strobe in progress", 72 * old);
        push_b("R4 strobe period", 72 * lens[i]);
        push_b("R4 strobe period", 72 * lens[i]);
        drain();
        old = lens[i];
      end
    end

    repeat (10) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule